// File: doc/BRIEF.md
# AC97-Style Link Frame Engine (Controller Side)

This block is the controller end of a five-wire time-multiplexed audio link. The codec supplies the bit clock, and the block produces the frame sync from it. Every frame is 256 bit clocks long. It starts with a 16-bit tag slot, followed by twelve 20-bit data slots. The block shifts the frame out on the playback line and rebuilds the same slot structure from the capture line. It also holds the codec's active-low reset low for a programmable number of bit clocks after its own reset.

On the host side, the next frame is presented in parallel as a tag word, twelve slot words and a per-slot valid mask. A boundary indicator tells the host when those words will be taken. Captured frames come back as a parallel tag and slot words, together with a one-period completion strobe.

Top module: `ac97f_link_engine`

## Requirements
- R1: While `rst_n` is low, and for the first RST_HOLD rising bit-clock edges after it rises, `codec_rst_n`, `sync`, `sdata_out` and `rx_done` are all low. `codec_rst_n` goes high at the RST_HOLD-th rising edge and stays high.
- R2: The first frame starts at the rising edge that follows the release of `codec_rst_n`. From that edge on, `sync` is high.
- R3: In every frame, `sync` is high for exactly TAG_W (16) bit clocks and low for the other FRAME_LEN-TAG_W (240). Frames follow each other with a period of FRAME_LEN (256) bit clocks.
- R4: Frame bit p is on `sdata_out` from the p-th rising edge of the frame. Bits 0..15 are `tx_tag[15]` down to `tx_tag[0]`. For p >= 16, with s=(p-16)/20 and b=19-((p-16)%20), the bit is `tx_slots[s*20+b]`. Each slot is therefore sent MSB first, and slot word s sits at `tx_slots[s*20 +: 20]`.
- R5: A data slot whose `tx_valid[s]` bit is 0 is sent as all zeros, whatever `tx_slots` holds.
- R6: The host words are sampled only at the rising edge that opens a frame. Changes made during a frame do not affect the bits already being sent.
- R7: `tx_latch` is high exactly during the last bit period of each frame, the one before the sampling edge. It is never high before the link is running.
- R8: `sdata_in` is sampled on falling edges, using the same bit mapping as R4. After the falling edge of bit 255, `rx_tag` and `rx_slots` hold the whole captured frame, and `rx_done` is high for exactly one bit-clock period.
- R9: Captured words hold their value until the next frame is complete. Nothing is captured before the first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock supplied by the codec |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sdata_in | input | 1 | Capture serial data from the codec |
| tx_tag | input | 16 | Tag word for the next frame |
| tx_slots | input | 240 | Twelve 20-bit slot words for the next frame, slot s at [s*20 +: 20] |
| tx_valid | input | 12 | Per-slot enable; a 0 sends that slot as zeros |
| sync | output | 1 | Frame sync to the codec |
| sdata_out | output | 1 | Playback serial data to the codec |
| codec_rst_n | output | 1 | Active-low codec reset |
| tx_latch | output | 1 | High in the bit period before host words are taken |
| rx_tag | output | 16 | Captured tag word |
| rx_slots | output | 240 | Captured slot words, slot s at [s*20 +: 20] |
| rx_done | output | 1 | One-period strobe when a captured frame is complete |

## Verification
At the frame boundary, two things happen in the same bit period. The capture side finishes a frame on the falling edge of bit 255, and the playback side reloads its shift register from the host words on the next rising edge. The bench provokes this by running frames back to back with different playback and capture patterns, and by rewriting the host words in the middle of one frame. It then checks three things: the playback bits carry only the words present at the opening edge, the captured words hold through the first bit of the next frame, and the completion strobe lasts exactly one period.

// File: rtl/ac97f_pkg.sv
package ac97f_pkg;

  // total bits in one frame: tag slot plus all data slots
  function automatic int unsigned frame_bits(input int unsigned tag_w,
                                             input int unsigned slot_w,
                                             input int unsigned n_slots);
    return tag_w + slot_w * n_slots;
  endfunction

  // true while a frame position lies inside the tag slot
  function automatic logic in_tag(input int unsigned pos, input int unsigned tag_w);
    return pos < tag_w;
  endfunction

endpackage

// File: rtl/ac97f_timebase.sv
module ac97f_timebase #(
  parameter int unsigned TAG_W     = 16,
  parameter int unsigned FRAME_LEN = 256,
  parameter int unsigned RST_HOLD  = 4,
  localparam int unsigned POS_W    = $clog2(FRAME_LEN),
  localparam int unsigned HOLD_W   = $clog2(RST_HOLD + 1)
) (
  input  logic             bclk,
  input  logic             rst_n,
  output logic             codec_rst_n,
  output logic             sync,
  output logic             frame_load,
  output logic             frame_live,
  output logic [POS_W-1:0] bit_pos
);

  localparam logic [POS_W-1:0]  LAST      = POS_W'(FRAME_LEN - 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(RST_HOLD - 1);

  logic [HOLD_W-1:0] hold_q;
  logic              rel_q;
  logic [POS_W-1:0]  pos_q;
  logic [POS_W-1:0]  pos_nxt;
  logic              sync_q;
  logic              live_q;

  assign pos_nxt = (pos_q == LAST) ? '0 : pos_q + 1'b1;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      rel_q  <= 1'b0;
      pos_q  <= LAST;
      sync_q <= 1'b0;
      live_q <= 1'b0;
    end else if (!rel_q) begin
      if (hold_q == HOLD_LAST) rel_q <= 1'b1;
      else                     hold_q <= hold_q + 1'b1;
    end else begin
      pos_q  <= pos_nxt;
      sync_q <= ac97f_pkg::in_tag(int'(pos_nxt), TAG_W);
      if (pos_q == LAST) live_q <= 1'b1;
    end
  end

  assign codec_rst_n = rel_q;
  assign sync        = sync_q;
  assign frame_load  = rel_q && (pos_q == LAST);
  assign frame_live  = live_q;
  assign bit_pos     = pos_q;

endmodule

// File: rtl/ac97f_tx_ser.sv
module ac97f_tx_ser #(
  parameter int unsigned TAG_W     = 16,
  parameter int unsigned SLOT_W    = 20,
  parameter int unsigned N_SLOTS   = 12,
  localparam int unsigned FRAME_LEN = TAG_W + SLOT_W * N_SLOTS
) (
  input  logic                      bclk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [TAG_W-1:0]          tx_tag,
  input  logic [N_SLOTS*SLOT_W-1:0] tx_slots,
  input  logic [N_SLOTS-1:0]        tx_valid,
  output logic                      sdata_out
);

  logic [FRAME_LEN-1:0] frame_word;
  logic [FRAME_LEN-1:0] shift_q;

  assign frame_word[FRAME_LEN-1 -: TAG_W] = tx_tag;

  // slot 0 follows the tag; each later slot sits further toward the LSB
  for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
    assign frame_word[FRAME_LEN-1-TAG_W-k*SLOT_W -: SLOT_W] =
      tx_valid[k] ? tx_slots[k*SLOT_W +: SLOT_W] : '0;
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n)    shift_q <= '0;
    else if (load) shift_q <= frame_word;
    else           shift_q <= shift_q << 1;
  end

  assign sdata_out = shift_q[FRAME_LEN-1];

endmodule

// File: rtl/ac97f_rx_des.sv
module ac97f_rx_des #(
  parameter int unsigned TAG_W     = 16,
  parameter int unsigned SLOT_W    = 20,
  parameter int unsigned N_SLOTS   = 12,
  localparam int unsigned FRAME_LEN = TAG_W + SLOT_W * N_SLOTS,
  localparam int unsigned POS_W     = $clog2(FRAME_LEN)
) (
  input  logic                      bclk,
  input  logic                      rst_n,
  input  logic                      live,
  input  logic [POS_W-1:0]          bit_pos,
  input  logic                      sdata_in,
  output logic [TAG_W-1:0]          rx_tag,
  output logic [N_SLOTS*SLOT_W-1:0] rx_slots,
  output logic                      rx_done
);

  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

  logic [FRAME_LEN-2:0] shift_q;
  logic [FRAME_LEN-1:0] full;
  logic [FRAME_LEN-1:0] frame_q;
  logic                 done_q;

  assign full = {shift_q, sdata_in};

  // capture side works on the falling edge, half a period after the codec drives
  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      frame_q <= '0;
      done_q  <= 1'b0;
    end else if (live) begin
      shift_q <= full[FRAME_LEN-2:0];
      if (bit_pos == LAST) begin
        frame_q <= full;
        done_q  <= 1'b1;
      end else begin
        done_q  <= 1'b0;
      end
    end
  end

  assign rx_tag  = frame_q[FRAME_LEN-1 -: TAG_W];
  assign rx_done = done_q;

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
    assign rx_slots[k*SLOT_W +: SLOT_W] = frame_q[FRAME_LEN-1-TAG_W-k*SLOT_W -: SLOT_W];
  end

endmodule

// File: rtl/ac97f_link_engine.sv
module ac97f_link_engine #(
  parameter int unsigned TAG_W    = 16,
  parameter int unsigned SLOT_W   = 20,
  parameter int unsigned N_SLOTS  = 12,
  parameter int unsigned RST_HOLD = 4
) (
  input  logic                      bclk,
  input  logic                      rst_n,
  input  logic                      sdata_in,
  input  logic [TAG_W-1:0]          tx_tag,
  input  logic [N_SLOTS*SLOT_W-1:0] tx_slots,
  input  logic [N_SLOTS-1:0]        tx_valid,
  output logic                      sync,
  output logic                      sdata_out,
  output logic                      codec_rst_n,
  output logic                      tx_latch,
  output logic [TAG_W-1:0]          rx_tag,
  output logic [N_SLOTS*SLOT_W-1:0] rx_slots,
  output logic                      rx_done
);

  localparam int unsigned FRAME_LEN = ac97f_pkg::frame_bits(TAG_W, SLOT_W, N_SLOTS);
  localparam int unsigned POS_W     = $clog2(FRAME_LEN);

  // named internal events shared by the pieces below
  logic             frame_load;
  logic             frame_live;
  logic [POS_W-1:0] bit_pos;

  ac97f_timebase #(
    .TAG_W(TAG_W), .FRAME_LEN(FRAME_LEN), .RST_HOLD(RST_HOLD)
  ) u_tb (
    .bclk(bclk), .rst_n(rst_n), .codec_rst_n(codec_rst_n), .sync(sync),
    .frame_load(frame_load), .frame_live(frame_live), .bit_pos(bit_pos)
  );

  ac97f_tx_ser #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)
  ) u_tx (
    .bclk(bclk), .rst_n(rst_n), .load(frame_load), .tx_tag(tx_tag),
    .tx_slots(tx_slots), .tx_valid(tx_valid), .sdata_out(sdata_out)
  );

  ac97f_rx_des #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)
  ) u_rx (
    .bclk(bclk), .rst_n(rst_n), .live(frame_live), .bit_pos(bit_pos),
    .sdata_in(sdata_in), .rx_tag(rx_tag), .rx_slots(rx_slots), .rx_done(rx_done)
  );

  assign tx_latch = frame_load;

endmodule

// File: rtl/ac97f_link_engine_chk.sv
module ac97f_link_engine_chk #(
  parameter int unsigned TAG_W     = 16,
  parameter int unsigned FRAME_LEN = 256
) (
  input logic bclk,
  input logic rst_n,
  input logic codec_rst_n,
  input logic sync,
  input logic sdata_out,
  input logic tx_latch,
  input logic rx_done
);

  logic [31:0] hi_cnt_q;
  logic [31:0] lo_cnt_q;
  logic        seen_fall_q;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt_q    <= '0;
      lo_cnt_q    <= '0;
      seen_fall_q <= 1'b0;
    end else begin
      hi_cnt_q <= sync ? hi_cnt_q + 1 : '0;
      lo_cnt_q <= sync ? '0 : lo_cnt_q + 1;
      if (!sync && hi_cnt_q != 0) seen_fall_q <= 1'b1;
    end
  end

  AST_QUIET_IN_RESET: assert property (@(posedge bclk) disable iff (!rst_n)
    !codec_rst_n |-> (!sync && !sdata_out && !tx_latch)); // R1

  AST_RESET_STAYS_OFF: assert property (@(posedge bclk) disable iff (!rst_n)
    codec_rst_n |=> codec_rst_n); // R1

  AST_SYNC_HIGH_LEN: assert property (@(posedge bclk) disable iff (!rst_n)
    $fell(sync) |-> (hi_cnt_q == TAG_W)); // R3

  AST_SYNC_LOW_LEN: assert property (@(posedge bclk) disable iff (!rst_n)
    ($rose(sync) && seen_fall_q) |-> (lo_cnt_q == FRAME_LEN - TAG_W)); // R3

  AST_LATCH_OPENS_FRAME: assert property (@(posedge bclk) disable iff (!rst_n)
    tx_latch |=> sync); // R7

  AST_FRAME_NEEDS_LATCH: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(sync) |-> $past(tx_latch)); // R2

  AST_DONE_ONE_PERIOD: assert property (@(negedge bclk) disable iff (!rst_n)
    rx_done |=> !rx_done); // R8

endmodule

bind ac97f_link_engine ac97f_link_engine_chk #(
  .TAG_W(TAG_W), .FRAME_LEN(FRAME_LEN)
) chk_i (
  .bclk(bclk), .rst_n(rst_n), .codec_rst_n(codec_rst_n), .sync(sync),
  .sdata_out(sdata_out), .tx_latch(tx_latch), .rx_done(rx_done)
);

// File: tb/ac97f_link_engine_tb_top.sv
module ac97f_link_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 16, SLOT_W = 20, N_SLOTS = 12, RST_HOLD = 4;
  localparam int NBITS = TAG_W + SLOT_W * N_SLOTS;

  logic bclk = 1'b0, rst_n = 1'b0, sdata_in = 1'b0;
  logic [TAG_W-1:0] tx_tag = '0;
  logic [N_SLOTS*SLOT_W-1:0] tx_slots = '0;
  logic [N_SLOTS-1:0] tx_valid = '0;
  logic sync, sdata_out, codec_rst_n, tx_latch, rx_done;
  logic [TAG_W-1:0] rx_tag;
  logic [N_SLOTS*SLOT_W-1:0] rx_slots;

  ac97f_link_engine #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS), .RST_HOLD(RST_HOLD)) dut_i (
    .bclk(bclk), .rst_n(rst_n), .sdata_in(sdata_in), .tx_tag(tx_tag), .tx_slots(tx_slots),
    .tx_valid(tx_valid), .sync(sync), .sdata_out(sdata_out), .codec_rst_n(codec_rst_n),
    .tx_latch(tx_latch), .rx_tag(rx_tag), .rx_slots(rx_slots), .rx_done(rx_done));

  always #(CLK_PERIOD/2) bclk = ~bclk;

  int checks = 0, fails = 0;
  bit have_prev = 0;
  logic [TAG_W-1:0] prev_tag;
  logic [N_SLOTS*SLOT_W-1:0] prev_slots;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [NBITS-1:0] act, input logic [NBITS-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // bit p of a frame, computed from the slot arithmetic of the requirements
  function automatic bit frame_bit(input int p, input logic [TAG_W-1:0] tg,
                                   input logic [N_SLOTS*SLOT_W-1:0] sl,
                                   input logic [N_SLOTS-1:0] vl);
    int s, b;
    if (p < TAG_W) return tg[TAG_W-1-p];
    s = (p - TAG_W) / SLOT_W;
    b = SLOT_W - 1 - ((p - TAG_W) % SLOT_W);
    return vl[s] ? sl[s*SLOT_W + b] : 1'b0;
  endfunction

  function automatic logic [N_SLOTS*SLOT_W-1:0] mk_slots(input int seed);
    logic [N_SLOTS*SLOT_W-1:0] v;
    for (int k = 0; k < N_SLOTS; k++)
      v[k*SLOT_W +: SLOT_W] = SLOT_W'((k + 1) * 32'h0004_D3A7 + seed * 32'h0001_1111);
    return v;
  endfunction

  task automatic run_frame(input logic [TAG_W-1:0] tg, input logic [N_SLOTS*SLOT_W-1:0] sl,
                           input logic [N_SLOTS-1:0] vl, input logic [TAG_W-1:0] rtg,
                           input logic [N_SLOTS*SLOT_W-1:0] rsl, input bit disturb);
    logic [NBITS-1:0] got, exp;
    int sync_bad = 0, latch_bad = 0, done_bad = 0;
    tx_tag = tg; tx_slots = sl; tx_valid = vl;
    for (int p = 0; p < NBITS; p++) begin
      @(posedge bclk);
      #1 sdata_in = frame_bit(p, rtg, rsl, '1);
      #1 got[NBITS-1-p] = sdata_out;
      exp[NBITS-1-p] = frame_bit(p, tg, sl, vl);
      if (sync !== (p < TAG_W)) sync_bad++;
      if (tx_latch !== (p == NBITS-1)) latch_bad++;
      if (disturb && p == 100) begin
        tx_tag = ~tg; tx_slots = ~sl; tx_valid = ~vl;
      end
      @(negedge bclk);
      #1 if (rx_done !== (p == NBITS-1)) done_bad++;
      if (p == 0 && have_prev)
        check(rx_tag === prev_tag && rx_slots === prev_slots, "R9", "capture held into next frame",
              NBITS'({rx_tag, rx_slots}), NBITS'({prev_tag, prev_slots}));
    end
    check(got === exp, disturb ? "R6" : (vl != '1 ? "R5" : "R4"), "serialized frame", got, exp);
    check(sync_bad == 0, "R2/R3", "sync window mismatches", NBITS'(sync_bad), '0);
    check(latch_bad == 0, "R7", "latch indicator mismatches", NBITS'(latch_bad), '0);
    check(done_bad == 0, "R8", "done strobe mismatches", NBITS'(done_bad), '0);
    check(rx_tag === rtg, "R8", "captured tag", NBITS'(rx_tag), NBITS'(rtg));
    check(rx_slots === rsl, "R8", "captured slots", NBITS'(rx_slots), NBITS'(rsl));
    prev_tag = rtg; prev_slots = rsl; have_prev = 1;
  endtask

  initial begin
    repeat (100000) @(posedge bclk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    sdata_in = 1'b1;  // capture line busy before any frame: must be ignored (R9)
    #1;
    check(!codec_rst_n && !sync && !sdata_out && !rx_done, "R1", "outputs in reset",
          NBITS'({codec_rst_n, sync, sdata_out, rx_done}), '0);
    repeat (3) @(posedge bclk);
    @(negedge bclk) rst_n = 1'b1;
    for (int k = 1; k <= RST_HOLD; k++) begin
      @(posedge bclk);
      #2 check(codec_rst_n === (k == RST_HOLD) && !sync && !sdata_out, "R1",
               "codec reset release edge", NBITS'({codec_rst_n, sync, sdata_out}),
               NBITS'({k == RST_HOLD, 2'b00}));
      check(!rx_done && !tx_latch === (k != RST_HOLD), "R9", "no capture before first frame",
            NBITS'({rx_done, tx_latch}), NBITS'({1'b0, k == RST_HOLD}));
    end
    run_frame(16'hA5C3, mk_slots(1), '1, 16'h9E01, mk_slots(7), 0);
    run_frame(16'h1234, mk_slots(2), 12'h5A3, 16'hFFFF, '1, 0);
    run_frame(16'hF0F0, mk_slots(3), 12'hC3F, 16'h0000, '0, 1);
    run_frame(16'hFFFF, '1, '0, 16'h5555, mk_slots(9), 0);
    run_frame(16'h8001, {N_SLOTS{20'hAAAAA}}, '1, 16'h7FFE, {N_SLOTS{20'h55555}}, 0);
    summary();
    $finish;
  end

endmodule